// File: doc/BRIEF.md
# SDRAM Bank Precharge and State Tracker

This block sits between a memory controller's request logic and the command pins of a four-bank SDRAM. It keeps a record of whether each bank has an open row. It turns accepted host requests into the matching command pattern on the chip-select, row-strobe, column-strobe and write-enable pins. It also drives the address and bank-select lines for each command form. A row can be closed in one bank or in every bank at once, and the address bit at position `AP_BIT` (A10) tells the device which form was meant.

Each bank has its own precharge recovery timer. The timer is loaded whenever that bank is closed. While it runs, a new row activation to that bank is refused. Reads or writes to a bank with no open row are also refused, as are activations to a bank that is already open and any unknown operation code. A refused request raises a one-cycle error flag, and the pins carry a no-operation in that cycle. Requests are offered with `req_valid` and are always taken. The block applies no back-pressure, so the host uses `bank_ready` and its own knowledge of open rows to decide what to send.

Top module: `sdram_bank_guard`

## Requirements
- R1: While reset is active, and in the first cycle after it, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `req_err` is low, `sd_addr` and `sd_ba` are zero, and `bank_ready` is all ones.
- R2: An activate request (op 0) to a bank whose `bank_ready` bit is high appears one cycle later as pins 0011, with `sd_addr` = row and `sd_ba` = bank. After that the bank is open and its `bank_ready` bit is low.
- R3: A read (op 1) or write (op 2) to an open bank appears one cycle later as pins 0101 or 0100, with `sd_addr` = the zero-extended column (A10 low) and `sd_ba` = bank.
- R4: A read or write to a bank with no open row produces NOP on the pins and `req_err` high in the next cycle.
- R5: A single-bank precharge (op 3) appears one cycle later as pins 0010, with A10 low, all other address bits zero and `sd_ba` = bank. The bank is then closed.
- R6: An all-bank precharge (op 4) appears one cycle later as pins 0010, with A10 high, the other address bits zero and `sd_ba` = 0. Every bank is then closed.
- R7: After a bank is closed, its `bank_ready` bit stays low for `TRP_CYC` cycles. An activate to it during that window is refused with NOP and `req_err`. The first accepted activate appears on the pins exactly `TRP_CYC` + 1 cycles after the precharge did.
- R8: An activate to a bank that already has an open row is refused with NOP and `req_err`.
- R9: A precharge to a bank that is already closed is accepted as a normal precharge and restarts that bank's `TRP_CYC` window.
- R10: With `req_valid` low, the pins carry NOP, `req_err` stays low, and no bank's state changes.
- R11: An operation code above 4 is refused with NOP and `req_err`, and it changes no bank's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle (always taken) |
| req_op | input | 3 | 0 activate, 1 read, 2 write, 3 precharge one, 4 precharge all |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row for activate |
| req_col | input | COL_W | Column for read or write |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines; bit AP_BIT selects all-bank precharge |
| sd_ba | output | BANK_W | Bank select |
| bank_ready | output | 2**BANK_W | Bank is closed and its recovery window has ended |
| req_err | output | 1 | Previous request was refused |

## Verification
The bench sends an activate on every cycle of the recovery window and one cycle after it ends. A timer that is off by one cycle either lets an activate through early or refuses the first legal one. It checks the A10 and bank-select patterns of both precharge forms and the A10 level on reads, because swapping the two precharge forms would close the wrong set of banks. It precharges banks that are already closed and confirms that the window restarts, then sends reads to closed banks, activates to open banks and unknown codes, each of which must produce a NOP with the error flag. A long random mix, checked against a bench model of the open state and timers of all four banks, catches state that leaks between banks.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;
  localparam logic [2:0] OP_ACT     = 3'd0;
  localparam logic [2:0] OP_RD      = 3'd1;
  localparam logic [2:0] OP_WR      = 3'd2;
  localparam logic [2:0] OP_PRE_ONE = 3'd3;
  localparam logic [2:0] OP_PRE_ALL = 3'd4;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam pins_t PINS_WR  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
  localparam pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int TRP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_set,
  input  logic close,
  output logic is_open,
  output logic ready
);
  localparam int CNT_W = $clog2(TRP_CYC + 1);
  localparam logic [CNT_W-1:0] TRP_LD = CNT_W'(TRP_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      is_open <= 1'b0;
    end else if (close) begin
      cnt_q   <= TRP_LD;
      is_open <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (open_set) is_open <= 1'b1;
    end
  end

  assign ready = !is_open && (cnt_q == '0);

  // R7: the window never exceeds the configured length
  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= TRP_LD);
  // R9: every close, even of an idle bank, restarts the full window
  p_close_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (cnt_q == TRP_LD && !is_open));
  // R7: the request checker only opens a bank whose window has ended
  p_open_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    open_set |-> ready);
  // R2: opening and closing never collide
  p_set_close_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open_set, close}));
endmodule

// File: rtl/cmd_encoder.sv
module cmd_encoder
  import bank_guard_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output pins_t             pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba
);
  always_comb begin
    pins = PINS_NOP;
    addr = '0;
    ba   = '0;
    if (issue) begin
      case (op)
        OP_ACT: begin
          pins = PINS_ACT;
          addr = ADDR_W'(row);
          ba   = bank;
        end
        OP_RD: begin
          pins = PINS_RD;
          addr = ADDR_W'(col);
          ba   = bank;
        end
        OP_WR: begin
          pins = PINS_WR;
          addr = ADDR_W'(col);
          ba   = bank;
        end
        OP_PRE_ONE: begin
          pins = PINS_PRE;
          ba   = bank;
        end
        OP_PRE_ALL: begin
          pins         = PINS_PRE;
          addr[AP_BIT] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import bank_guard_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 11,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int AP_BIT  = 10,
  parameter int TRP_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [ADDR_W-1:0]        sd_addr,
  output logic [BANK_W-1:0]        sd_ba,
  output logic [(1<<BANK_W)-1:0]   bank_ready,
  output logic                     req_err
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] bank_open, open_set, close;
  logic             legal, issue, reject;
  pins_t            pins_d, pins_q;
  logic [ADDR_W-1:0] addr_d;
  logic [BANK_W-1:0] ba_d;

  always_comb begin
    case (req_op)
      OP_ACT:                 legal = bank_ready[req_bank];
      OP_RD, OP_WR:           legal = bank_open[req_bank];
      OP_PRE_ONE, OP_PRE_ALL: legal = 1'b1;
      default:                legal = 1'b0;
    endcase
  end

  assign issue  = req_valid && legal;
  assign reject = req_valid && !legal;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign open_set[b] = issue && (req_op == OP_ACT) && (req_bank == BANK_W'(b));
    assign close[b]    = issue && ((req_op == OP_PRE_ALL) ||
                                   ((req_op == OP_PRE_ONE) && (req_bank == BANK_W'(b))));
    bank_timer #(.TRP_CYC(TRP_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .open_set(open_set[b]), .close(close[b]),
      .is_open(bank_open[b]), .ready(bank_ready[b])
    );
  end

  cmd_encoder #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) i_enc (
    .issue(issue), .op(req_op), .bank(req_bank), .row(req_row), .col(req_col),
    .pins(pins_d), .addr(addr_d), .ba(ba_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= PINS_NOP;
      sd_addr <= '0;
      sd_ba   <= '0;
      req_err <= 1'b0;
    end else begin
      pins_q  <= pins_d;
      sd_addr <= addr_d;
      sd_ba   <= ba_d;
      req_err <= reject;
    end
  end

  assign sd_cs_n  = pins_q.cs_n;
  assign sd_ras_n = pins_q.ras_n;
  assign sd_cas_n = pins_q.cas_n;
  assign sd_we_n  = pins_q.we_n;

  // R3: a column command on the pins targets a bank with an open row
  p_rw_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> bank_open[sd_ba]);
  // R2: an activate on the pins leaves its bank open and not ready
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n) |-> (bank_open[sd_ba] && !bank_ready[sd_ba]));
  // R4: a refused request never reaches the pins as a command
  p_err_sends_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (pins_q == PINS_NOP));
  // R6: an all-bank precharge leaves no bank open
  p_pre_all_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PINS_PRE && sd_addr[AP_BIT]) |-> (bank_open == '0));
  // R11: unknown codes are refused
  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > OP_PRE_ALL) |=> req_err);
endmodule

// File: tb/test_sdram_bank_guard.sv
module test_sdram_bank_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TRP = 3;
  localparam int AP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_err;
  logic [10:0] sd_addr;
  logic [1:0]  sd_ba;
  logic [3:0]  bank_ready;

  sdram_bank_guard #(.TRP_CYC(TRP)) i_sdram_bank_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .bank_ready(bank_ready), .req_err(req_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_open[4];
  int m_cnt[4];

  function automatic logic [3:0] m_ready();
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = !m_open[b] && (m_cnt[b] == 0);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int op, int bank, logic [10:0] row, logic [7:0] col);
    logic [3:0]  e_pins = 4'b0111;
    logic [10:0] e_addr = '0;
    logic [1:0]  e_ba = '0;
    bit legal = 0;
    bit e_err;
    string tag = "R10";
    @(negedge clk);
    req_valid = v; req_op = 3'(op); req_bank = 2'(bank); req_row = row; req_col = col;
    if (v) begin
      case (op)
        0: begin
          legal = (m_cnt[bank] == 0) && !m_open[bank];
          tag = legal ? "R2" : (m_open[bank] ? "R8" : "R7");
          if (legal) begin e_pins = 4'b0011; e_addr = row; e_ba = 2'(bank); end
        end
        1, 2: begin
          legal = m_open[bank];
          tag = legal ? "R3" : "R4";
          if (legal) begin e_pins = (op == 1) ? 4'b0101 : 4'b0100; e_addr = 11'(col); e_ba = 2'(bank); end
        end
        3: begin
          legal = 1; tag = m_open[bank] ? "R5" : "R9";
          e_pins = 4'b0010; e_ba = 2'(bank);
        end
        4: begin
          legal = 1; tag = "R6";
          e_pins = 4'b0010; e_addr[AP] = 1'b1;
        end
        default: tag = "R11";
      endcase
    end
    e_err = v && !legal;
    for (int b = 0; b < 4; b++) begin
      if (legal && (op == 4 || (op == 3 && b == bank))) begin
        m_cnt[b] = TRP; m_open[b] = 0;
      end else begin
        if (m_cnt[b] > 0) m_cnt[b]--;
        if (legal && op == 0 && b == bank) m_open[b] = 1;
      end
    end
    @(posedge clk); #1;
    check(tag, {15'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba, req_err},
               {15'd0, e_pins, e_addr, e_ba, e_err});
    check("R7 ready", {28'd0, bank_ready}, {28'd0, m_ready()});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_cnt[b] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while reset is held
    check("R1", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_err, bank_ready},
                {4'b0111, 1'b0, 4'b1111});
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {21'd0, sd_addr, sd_ba}, 32'd0);
    step(0, 0, 0, 0, 0);              // R10
    step(1, 0, 1, 11'h5A5, 0);        // R2
    step(1, 1, 1, 0, 8'hFF);          // R3, A10 must stay low
    step(1, 2, 1, 0, 8'h3C);          // R3
    step(1, 1, 2, 0, 8'h11);          // R4 closed bank
    step(1, 2, 3, 0, 8'h22);          // R4
    step(1, 0, 1, 11'h123, 0);        // R8 already open
    step(1, 3, 1, 0, 0);              // R5
    for (int i = 0; i < TRP; i++) step(1, 0, 1, 11'h7FF, 0); // R7 refused inside window
    step(1, 0, 1, 11'h7FF, 0);        // R7 first accepted activate
    step(1, 3, 3, 0, 0);              // R9 closed bank precharge
    step(1, 3, 3, 0, 0);              // R9 restart window
    step(1, 0, 3, 11'h001, 0);        // R7 still refused after restart
    step(1, 0, 0, 11'h0F0, 0);        // R2
    step(1, 0, 2, 11'h400, 0);        // R2 row with A10 set
    step(1, 4, 2, 0, 0);              // R6
    step(1, 1, 0, 0, 8'h01);          // R4 all closed now
    step(1, 5, 0, 0, 0);              // R11
    step(1, 7, 2, 0, 0);              // R11
    step(0, 0, 0, 11'h555, 0);        // R10
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % 6, $urandom % 4, 11'($urandom), 8'($urandom));
    end
    done = 1;
    finish_run();
  end
endmodule